// File: doc/BRIEF.md
# Serial Memory Read Controller

This block implements the read side of a two-wire serial memory slave. It watches the clock and data lines of an I2C bus, decodes the control byte the master sends after a START, and answers with data from a memory array. The array sits outside the block and has a synchronous read port. The block keeps an internal address pointer. A write header followed by a word address loads that pointer; this is the "dummy write" of a random read. The pointer then advances by one for every byte sent to the master.

The master has three ways to read:
- A random read sets the address and then reads after a repeated START.
- A current-address read skips the address phase and continues from where the pointer stands.
- Either kind becomes a sequential read when the master acknowledges each byte. The stream stops only when the master leaves the acknowledge slot high.

Both bus lines pass through a two-stage synchroniser before any edge is detected. The data line is only ever pulled low: the output is an enable that drives the pad low.

A parameter selects one or two word-address bytes. In one-byte mode with more than 256 locations, the low device-select bit positions of the control byte carry the upper address bits. Those bits are not compared against the strap pins.

Top module: `serial_mem_reader`

## Requirements
- R1: After reset, `sda_oe_o` and `mem_rd_o` are low and the address pointer is zero, so a current-address read issued first returns the byte at address 0.
- R2: A control byte is accepted when bits 7:4 equal 4'b1010 and bits 3:2 equal `straps_i[2:1]`. With the defaults (one address byte, 9-bit address), bit 1 is the page bit and is not compared, and bit 0 set means read. The block acknowledges an accepted control byte by pulling SDA low in the ninth clock.
- R3: A control byte that does not match gets no acknowledge. SDA stays released for the rest of that transaction, including any later bytes, until the next START. The address pointer is left unchanged.
- R4: A write control byte followed by a word byte acknowledges the word byte and loads the pointer with {control bit 1, word byte}. A repeated START and a read control byte then return the byte at that address. A third byte in the write transaction gets no acknowledge.
- R5: A current-address read returns the byte one past the last byte sent in any earlier transaction.
- R6: Data bytes go out MSB first. When the master acknowledges a byte (SDA low in the ninth clock), the block sends the byte at the next address.
- R7: During a sequential read the pointer wraps from the top address (511) to 0.
- R8: When the master leaves the acknowledge slot high, the block releases SDA and starts no further memory reads until a STOP or START, even if the master keeps clocking. After a STOP the block stays released.
- R9: The block changes `sda_oe_o` only while SCL is low.
- R10: A START is recognised in any state, including in the middle of a byte. It restarts control-byte decoding from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull the data line low when high |
| straps_i | input | 3 | Device-select strap pins |
| mem_addr_o | output | AW | Read address to the memory array |
| mem_rd_o | output | 1 | One-cycle read strobe; data is expected the next cycle |
| mem_data_i | input | 8 | Read data from the memory array |

## Verification
The assertions take for granted that the bus clock changes slowly compared with the system clock. They also assume the master moves SDA only while SCL is low, except when it signals START or STOP. Under those conditions, a data change is never seen as a start or stop, and the block's own drive changes fall inside the low phase. The stimulus holds every SCL phase for several system clocks. It changes master data a quarter bit after SCL falls and samples the line in the high phase. It also brings SDA high before it raises SCL for a repeated START.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } rd_state_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Select-bit positions that carry address bits instead of strap values.
    function automatic logic [2:0] page_mask(input int unsigned pw);
        logic [2:0] m;
        for (int i = 0; i < 3; i++) begin
            m[i] = (i < pw);
        end
        return m;
    endfunction

    function automatic logic ctrl_match(input logic [7:0] cb,
                                        input logic [3:0] dtype,
                                        input logic [2:0] straps,
                                        input logic [2:0] pmask);
        return (cb[7:4] == dtype) && (((cb[3:1] ^ straps) & ~pmask) == 3'b000);
    endfunction

    function automatic logic [15:0] word_addr(input logic       two_byte,
                                              input logic [7:0] hi,
                                              input logic [7:0] lo,
                                              input logic [2:0] pg,
                                              input logic [2:0] pmask);
        if (two_byte) begin
            return {hi, lo};
        end
        return {5'b00000, pg & pmask, lo};
    endfunction

endpackage

// File: rtl/smr_bus_sync.sv
module smr_bus_sync
    import smr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic [1:0] raw;
    logic [1:0] pipe [STAGES];
    logic [1:0] cur;
    logic [1:0] prev_q;

    assign raw = {scl_i, sda_i};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= 2'b11;
                else     pipe[s] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= 2'b11;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign cur = pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 2'b11;
        else     prev_q <= cur;
    end

    // bit 1 = SCL, bit 0 = SDA
    always_comb begin
        evt_o.scl_lvl  = cur[1];
        evt_o.sda_lvl  = cur[0];
        evt_o.scl_rise = cur[1] & ~prev_q[1];
        evt_o.scl_fall = ~cur[1] & prev_q[1];
        evt_o.start    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
        evt_o.stop     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
    end
endmodule

// File: rtl/smr_addr_ptr.sv
module smr_addr_ptr #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          incr_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (load_i) addr_q <= load_val_i;
        else if (incr_i) addr_q <= addr_q + 1'b1;
    end

    assign addr_o = addr_q;

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (incr_i && !load_i && (addr_q == '1)) |=> (addr_o == '0));
endmodule

// File: rtl/smr_fsm.sv
module smr_fsm
    import smr_pkg::*;
#(
    parameter int          AW         = 9,
    parameter int          ADDR_BYTES = 1,
    parameter logic [3:0]  DEV_TYPE   = 4'b1010,
    parameter int          PAGE_W     = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt_i,
    input  logic [2:0]    straps_i,
    input  logic [7:0]    mem_data_i,
    output logic          oe_o,
    output logic          fetch_o,
    output logic          load_o,
    output logic [AW-1:0] load_val_o
);
    localparam logic [2:0] PMASK    = page_mask(PAGE_W);
    localparam logic       TWO_BYTE = (ADDR_BYTES == 2);

    rd_state_e     st_q;
    logic [3:0]    cnt_q;
    logic [7:0]    rx_q;
    logic [7:0]    tx_q;
    logic [7:0]    hi_q;
    logic [2:0]    pg_q;
    logic          rw_q;
    logic          byte_idx_q;
    logic          oe_q;
    logic          fetch_q;
    logic          pend_q;
    logic          load_q;
    logic [AW-1:0] load_val_q;

    logic [7:0]    rx_next;
    logic          last_byte;
    logic [15:0]   word_w;

    assign rx_next   = {rx_q[6:0], evt_i.sda_lvl};
    assign last_byte = !TWO_BYTE || byte_idx_q;
    assign word_w    = word_addr(TWO_BYTE, hi_q, rx_next, pg_q, PMASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cnt_q      <= 4'd0;
            rx_q       <= 8'd0;
            tx_q       <= 8'd0;
            hi_q       <= 8'd0;
            pg_q       <= 3'd0;
            rw_q       <= 1'b0;
            byte_idx_q <= 1'b0;
            oe_q       <= 1'b0;
            fetch_q    <= 1'b0;
            pend_q     <= 1'b0;
            load_q     <= 1'b0;
            load_val_q <= '0;
        end else begin
            fetch_q <= 1'b0;
            load_q  <= 1'b0;
            pend_q  <= fetch_q;
            if (pend_q) tx_q <= mem_data_i;

            if (evt_i.start) begin
                st_q  <= ST_CTRL;
                cnt_q <= 4'd0;
                oe_q  <= 1'b0;
            end else if (evt_i.stop) begin
                st_q  <= ST_IDLE;
                cnt_q <= 4'd0;
                oe_q  <= 1'b0;
            end else begin
                case (st_q)
                    ST_CTRL: if (evt_i.scl_rise) begin
                        rx_q <= rx_next;
                        if (cnt_q == 4'd7) begin
                            cnt_q <= 4'd0;
                            if (ctrl_match(rx_next, DEV_TYPE, straps_i, PMASK)) begin
                                st_q    <= ST_CTRL_ACK;
                                pg_q    <= rx_next[3:1];
                                rw_q    <= rx_next[0];
                                fetch_q <= rx_next[0];
                            end else begin
                                st_q <= ST_HOLD;
                            end
                        end else begin
                            cnt_q <= cnt_q + 4'd1;
                        end
                    end
                    ST_CTRL_ACK: if (evt_i.scl_fall) begin
                        if (cnt_q == 4'd0) begin
                            oe_q  <= 1'b1;
                            cnt_q <= 4'd1;
                        end else if (rw_q) begin
                            st_q  <= ST_TX;
                            oe_q  <= ~tx_q[7];
                            tx_q  <= {tx_q[6:0], 1'b0};
                            cnt_q <= 4'd1;
                        end else begin
                            st_q       <= ST_ADDR;
                            oe_q       <= 1'b0;
                            cnt_q      <= 4'd0;
                            byte_idx_q <= 1'b0;
                        end
                    end
                    ST_ADDR: if (evt_i.scl_rise) begin
                        rx_q <= rx_next;
                        if (cnt_q == 4'd7) begin
                            cnt_q <= 4'd0;
                            st_q  <= ST_ADDR_ACK;
                            if (last_byte) begin
                                load_q     <= 1'b1;
                                load_val_q <= word_w[AW-1:0];
                            end else begin
                                hi_q <= rx_next;
                            end
                        end else begin
                            cnt_q <= cnt_q + 4'd1;
                        end
                    end
                    ST_ADDR_ACK: if (evt_i.scl_fall) begin
                        if (cnt_q == 4'd0) begin
                            oe_q  <= 1'b1;
                            cnt_q <= 4'd1;
                        end else begin
                            oe_q  <= 1'b0;
                            cnt_q <= 4'd0;
                            if (last_byte) begin
                                st_q <= ST_HOLD;
                            end else begin
                                st_q       <= ST_ADDR;
                                byte_idx_q <= 1'b1;
                            end
                        end
                    end
                    ST_TX: if (evt_i.scl_fall) begin
                        if (cnt_q == 4'd8) begin
                            oe_q  <= 1'b0;
                            st_q  <= ST_TX_ACK;
                            cnt_q <= 4'd0;
                        end else begin
                            oe_q  <= ~tx_q[7];
                            tx_q  <= {tx_q[6:0], 1'b0};
                            cnt_q <= cnt_q + 4'd1;
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt_i.scl_rise && cnt_q == 4'd0) begin
                            if (!evt_i.sda_lvl) begin
                                fetch_q <= 1'b1;
                                cnt_q   <= 4'd1;
                            end else begin
                                st_q <= ST_HOLD;
                            end
                        end else if (evt_i.scl_fall && cnt_q == 4'd1) begin
                            st_q  <= ST_TX;
                            oe_q  <= ~tx_q[7];
                            tx_q  <= {tx_q[6:0], 1'b0};
                            cnt_q <= 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign oe_o       = oe_q;
    assign fetch_o    = fetch_q;
    assign load_o     = load_q;
    assign load_val_o = load_val_q;

    // R9
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_q != $past(oe_q)) |-> !evt_i.scl_lvl);

    // R3
    hold_released_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |-> !oe_q);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.stop |=> (!oe_q && st_q == ST_IDLE));

    // R6
    fetch_single_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_q |=> !fetch_q);

    // R10
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.start |=> (st_q == ST_CTRL && cnt_q == 4'd0));
endmodule

// File: rtl/serial_mem_reader.sv
module serial_mem_reader
    import smr_pkg::*;
#(
    parameter int         AW         = 9,
    parameter int         ADDR_BYTES = 1,
    parameter logic [3:0] DEV_TYPE   = 4'b1010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    input  logic [2:0]    straps_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rd_o,
    input  logic [7:0]    mem_data_i
);
    localparam int PAGE_RAW = (ADDR_BYTES == 1 && AW > 8) ? (AW - 8) : 0;
    localparam int PAGE_W   = (PAGE_RAW > 3) ? 3 : PAGE_RAW;

    bus_evt_t      evt;
    logic          fetch;
    logic          load;
    logic [AW-1:0] load_val;

    smr_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    smr_fsm #(
        .AW        (AW),
        .ADDR_BYTES(ADDR_BYTES),
        .DEV_TYPE  (DEV_TYPE),
        .PAGE_W    (PAGE_W)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .straps_i   (straps_i),
        .mem_data_i (mem_data_i),
        .oe_o       (sda_oe_o),
        .fetch_o    (fetch),
        .load_o     (load),
        .load_val_o (load_val)
    );

    smr_addr_ptr #(.AW(AW)) i_ptr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i (load_val),
        .incr_i     (fetch),
        .addr_o     (mem_addr_o)
    );

    assign mem_rd_o = fetch;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe_o && !mem_rd_o));
endmodule

// File: tb/test_serial_mem_reader.sv
`timescale 1ns/1ps
module test_serial_mem_reader;
    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam int Q     = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl_m = 1'b1;
    logic          m_low = 1'b0;
    logic          sda_oe;
    logic [2:0]    straps = 3'b101;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [7:0]    mem_q = 8'd0;
    wire           sda_line = ~(m_low | sda_oe);

    int checks = 0;
    int fails  = 0;
    int fetches = 0;
    int oe_hi = 0;
    int scl_hi_changes = 0;
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;

    serial_mem_reader i_serial_mem_reader (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .straps_i   (straps),
        .mem_addr_o (mem_addr),
        .mem_rd_o   (mem_rd),
        .mem_data_i (mem_q)
    );

    function automatic logic [7:0] pat(input int a);
        int v;
        v = ((a & 255) * 37 + 11) & 255;
        if (((a >> 8) & 1) != 0) v = v ^ 8'hA5;
        return v[7:0];
    endfunction

    function automatic logic [7:0] cb(input logic pg, input logic rw);
        return {4'b1010, 2'b10, pg, rw};
    endfunction

    always @(posedge clk) if (mem_rd) mem_q <= pat(int'(mem_addr));

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd) fetches++;
            if (sda_oe) oe_hi++;
            if (sda_oe != oe_prev && scl_m) scl_hi_changes++;
        end
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        m_low = 1'b0; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        wq(Q);
        m_low = ~b; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; wq(2*Q);
        scl_m = 1'b1; wq(Q);
        @(negedge clk); b = sda_line;
        wq(Q);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic stream(input int n, input int first, input string req);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            chk(req, v, pat((first + i) % DEPTH), "data byte");
        end
    endtask

    task automatic cur_read(input int n, input int first, input string req);
        logic ack;
        i2c_start();
        send_byte(cb(1'b0, 1'b1), ack);
        chk("R2", ack, 0, "read control ack");
        stream(n, first, req);
        i2c_stop();
    endtask

    task automatic rand_read(input int a, input int n, input string req);
        logic ack;
        i2c_start();
        send_byte(cb(a[8], 1'b0), ack);
        chk("R2", ack, 0, "write control ack");
        send_byte(a[7:0], ack);
        chk("R4", ack, 0, "word address ack");
        i2c_start();
        send_byte(cb(~a[8], 1'b1), ack);
        chk("R2", ack, 0, "read control ack, page bit ignored");
        stream(n, a, req);
        i2c_stop();
    endtask

    task automatic t_reset();
        chk("R1", sda_oe, 0, "sda_oe after reset");
        chk("R1", mem_rd, 0, "mem_rd after reset");
        cur_read(1, 0, "R1");
        cur_read(1, 1, "R5");
    endtask

    task automatic t_random();
        logic ack;
        rand_read(9'h1A3, 1, "R4");
        cur_read(1, 9'h1A4, "R5");
        i2c_start();
        send_byte(cb(1'b0, 1'b0), ack);
        send_byte(8'h10, ack);
        send_byte(8'h55, ack);
        chk("R4", ack, 1, "third write byte not acknowledged");
        i2c_stop();
        cur_read(1, 9'h010, "R4");
    endtask

    task automatic t_mismatch();
        logic ack;
        int hi0;
        i2c_start();
        send_byte(8'h5A, ack);
        chk("R3", ack, 1, "wrong type code nack");
        hi0 = oe_hi;
        send_byte(8'h00, ack);
        chk("R3", oe_hi - hi0, 0, "SDA released after mismatch");
        i2c_stop();
        i2c_start();
        send_byte({4'b1010, 2'b01, 1'b0, 1'b1}, ack);
        chk("R3", ack, 1, "wrong strap nack");
        i2c_stop();
        cur_read(1, 9'h011, "R3");
    endtask

    task automatic t_sequential();
        rand_read(9'h0FE, 5, "R6");
        cur_read(2, 9'h103, "R5");
    endtask

    task automatic t_wrap();
        rand_read(9'h1FE, 3, "R7");
    endtask

    task automatic t_nack();
        logic ack;
        logic [7:0] v;
        int f0, hi0;
        i2c_start();
        send_byte(cb(1'b0, 1'b1), ack);
        recv_byte(1'b0, v);
        chk("R8", v, pat(9'h001), "last byte before nack");
        f0 = fetches; hi0 = oe_hi;
        recv_byte(1'b0, v);
        chk("R8", v, 8'hFF, "bus released after nack");
        chk("R8", fetches - f0, 0, "no fetch after nack");
        chk("R8", oe_hi - hi0, 0, "no drive after nack");
        i2c_stop();
        wq(4*Q);
        chk("R8", sda_oe, 0, "released after stop");
        cur_read(1, 9'h002, "R8");
    endtask

    task automatic t_abort();
        logic ack;
        logic [7:0] v;
        i2c_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        i2c_start();
        send_byte(cb(1'b0, 1'b1), ack);
        chk("R10", ack, 0, "ack after restart mid byte");
        recv_byte(1'b0, v);
        chk("R10", v, pat(9'h003), "data after restart");
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 150000 cycles, expected completion earlier");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wq(5);
        @(negedge clk);
        rst = 1'b0;
        wq(4);
        @(negedge clk);
        t_reset();
        t_random();
        t_mismatch();
        t_sequential();
        t_wrap();
        t_nack();
        t_abort();
        chk("R9", scl_hi_changes, 0, "sda_oe changes while SCL high");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule